// File: doc/BRIEF.md
# Edge Interval Bit-Check Unit

This block decides whether a demodulated serial stream looks like a genuine transmitter signal. It does not decode the bits. It measures the spacing between consecutive edges of the data line. Time is counted in periods of a slower "extended" clock, which arrives as a one-cycle tick enable. The data line is sampled only on those ticks. Every measured interval is therefore a whole number of tick periods.

A check begins with a start strobe, which also captures the required number of good bits. The first edge after the strobe only starts the interval timer. Each later edge closes one interval, and that interval is compared with a programmable lower and upper limit. If the required number of consecutive intervals all fall inside the limits, the block pulses a pass flag and enters receive mode. In receive mode the sampled data is routed to the data output. If any interval is too short, or the line stays quiet past the upper limit, the block pulses a fail flag and returns to polling. Receive mode is sticky: only the return-to-polling command leaves it. A larger required count makes a successful check take proportionally longer.

Top module: `edge_bitcheck`

## Requirements
- R1: After reset, rxMode, passPulse and failPulse are 0 and dataOut is 1.
- R2: The interval counter advances only in cycles where tickEn is 1, and the data input is sampled only on those cycles. An interval is measured in ticks, not in clock cycles.
- R3: After a start strobe, the first edge starts the timer and is not counted. When bitCount consecutive intervals (the count captured at the strobe) each lie in the range limLo to limHi, both limits included, passPulse is 1 for exactly one cycle and rxMode becomes 1 in that same cycle.
- R4: An edge that closes an interval shorter than limLo ends the check. failPulse is 1 for one cycle and the block returns to polling with rxMode 0.
- R5: If a tick arrives with no edge once the running interval has reached limHi ticks, the check fails with a one-cycle failPulse. An interval of exactly limLo or exactly limHi ticks is accepted.
- R6: bitCount (4 bits, range 1 to 15) is captured only on a start strobe, so later changes have no effect on a running check. A start strobe with bitCount equal to 0 is ignored.
- R7: rxMode stays 1 until pollCmd is 1. pollCmd clears rxMode and aborts a running check without any pass or fail pulse. pollCmd has priority over startStb. A start strobe while rxMode is 1 is ignored.
- R8: While rxMode is 0, dataOut is 1. While rxMode is 1, dataOut follows the tick-sampled data input.
- R9: A start strobe with a nonzero bitCount during a running check restarts it. Good intervals counted before the restart are discarded, and the next edge again only starts the timer.
- R10: passPulse and failPulse are never 1 in the same cycle, and neither stays 1 for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle enable marking each extended clock period |
| dataIn | input | 1 | Demodulated data, already synchronous to clk |
| limLo | input | CNT_W | Shortest accepted interval, in ticks |
| limHi | input | CNT_W | Longest accepted interval, in ticks |
| bitCount | input | NEED_W | Required number of good intervals, captured at start |
| startStb | input | 1 | Starts (or restarts) a check |
| pollCmd | input | 1 | Returns the block to polling |
| passPulse | output | 1 | One-cycle pulse when the check succeeds |
| failPulse | output | 1 | One-cycle pulse when the check fails |
| rxMode | output | 1 | Receive-mode state |
| dataOut | output | 1 | Sampled data in receive mode, high in polling |

## Verification
The hardest situation to reach is one where counting in ticks and counting in clock cycles give different verdicts. A block that wrongly timed intervals in raw cycles would behave the same as a correct one whenever the tick is present on every cycle. The bench therefore slows the tick to one in three cycles and spaces the edges twelve cycles apart, which is four ticks. It first uses limits that four ticks satisfy, then limits that only twelve would satisfy, so the correct design passes the first case and fails the second. Restart and abort cases are reached by sending a start strobe or pollCmd midway through a partially accepted run of intervals, then continuing the edges to show that no stale progress survives.

// File: rtl/bitchk_pkg.sv
package bitchk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_CHECK = 2'd2,
    ST_RX    = 2'd3
  } chkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadNeed;
    logic clrGood;
    logic incGood;
    logic restartCnt;
  } dpCtrl_t;

  // flags from datapath to control
  typedef struct packed {
    logic tickSeen;
    logic edgeTick;
    logic tooShort;
    logic timeOut;
    logic lastBit;
    logic cfgOk;
  } dpStat_t;

endpackage

// File: rtl/bitchk_datapath.sv
module bitchk_datapath
  import bitchk_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NEED_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              dataIn,
  input  logic [CNT_W-1:0]  limLo,
  input  logic [CNT_W-1:0]  limHi,
  input  logic [NEED_W-1:0] bitCount,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat,
  output logic              dataSamp
);

  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [NEED_W:0]   GOOD_ONE = (NEED_W+1)'(1);

  logic [CNT_W-1:0]  intCnt;
  logic [NEED_W-1:0] goodCnt;
  logic [NEED_W-1:0] needReg;
  logic [NEED_W:0]   goodNext;

  // data sampled on the extended clock only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       dataSamp <= 1'b1;
    else if (tickEn) dataSamp <= dataIn;
  end

  // interval counter in tick units, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          intCnt <= '0;
    else if (ctrl.restartCnt)           intCnt <= CNT_ONE;
    else if (tickEn && intCnt != CNT_MAX) intCnt <= intCnt + CNT_ONE;
  end

  // consecutive good interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             goodCnt <= '0;
    else if (ctrl.clrGood) goodCnt <= '0;
    else if (ctrl.incGood) goodCnt <= goodCnt + NEED_W'(1);
  end

  // required count captured at start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              needReg <= '0;
    else if (ctrl.loadNeed) needReg <= bitCount;
  end

  assign goodNext = {1'b0, goodCnt} + GOOD_ONE;

  always_comb begin
    stat.tickSeen = tickEn;
    stat.edgeTick = tickEn && (dataIn != dataSamp);
    stat.tooShort = intCnt < limLo;
    stat.timeOut  = intCnt >= limHi;
    stat.lastBit  = goodNext == {1'b0, needReg};
    stat.cfgOk    = bitCount != '0;
  end

endmodule

// File: rtl/bitchk_control.sv
module bitchk_control
  import bitchk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startStb,
  input  logic    pollCmd,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    passPulse,
  output logic    failPulse,
  output logic    rxMode
);

  chkState_e state, stateNxt;
  logic passNxt, failNxt;
  logic startOk;

  assign startOk = startStb && stat.cfgOk;

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    passNxt  = 1'b0;
    failNxt  = 1'b0;
    if (pollCmd) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startOk) begin
            stateNxt      = ST_ARM;
            ctrl.loadNeed = 1'b1;
            ctrl.clrGood  = 1'b1;
          end
        end
        ST_ARM: begin
          if (startOk) begin
            ctrl.loadNeed = 1'b1;
            ctrl.clrGood  = 1'b1;
          end else if (stat.edgeTick) begin
            stateNxt        = ST_CHECK;
            ctrl.restartCnt = 1'b1;
          end
        end
        ST_CHECK: begin
          if (startOk) begin
            stateNxt      = ST_ARM;
            ctrl.loadNeed = 1'b1;
            ctrl.clrGood  = 1'b1;
          end else if (stat.edgeTick) begin
            if (stat.tooShort) begin
              stateNxt = ST_IDLE;
              failNxt  = 1'b1;
            end else if (stat.lastBit) begin
              stateNxt = ST_RX;
              passNxt  = 1'b1;
            end else begin
              ctrl.incGood    = 1'b1;
              ctrl.restartCnt = 1'b1;
            end
          end else if (stat.tickSeen && stat.timeOut) begin
            stateNxt = ST_IDLE;
            failNxt  = 1'b1;
          end
        end
        ST_RX: stateNxt = ST_RX;
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      passPulse <= 1'b0;
      failPulse <= 1'b0;
    end else begin
      state     <= stateNxt;
      passPulse <= passNxt;
      failPulse <= failNxt;
    end
  end

  assign rxMode = state == ST_RX;

endmodule

// File: rtl/edge_bitcheck.sv
module edge_bitcheck
  import bitchk_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int NEED_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              dataIn,
  input  logic [CNT_W-1:0]  limLo,
  input  logic [CNT_W-1:0]  limHi,
  input  logic [NEED_W-1:0] bitCount,
  input  logic              startStb,
  input  logic              pollCmd,
  output logic              passPulse,
  output logic              failPulse,
  output logic              rxMode,
  output logic              dataOut
);

  dpCtrl_t ctrl;
  dpStat_t stat;
  logic    dataSamp;

  bitchk_datapath #(.CNT_W(CNT_W), .NEED_W(NEED_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .dataIn   (dataIn),
    .limLo    (limLo),
    .limHi    (limHi),
    .bitCount (bitCount),
    .ctrl     (ctrl),
    .stat     (stat),
    .dataSamp (dataSamp)
  );

  bitchk_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .pollCmd   (pollCmd),
    .stat      (stat),
    .ctrl      (ctrl),
    .passPulse (passPulse),
    .failPulse (failPulse),
    .rxMode    (rxMode)
  );

  // polling mode holds the output high
  assign dataOut = rxMode ? dataSamp : 1'b1;

endmodule

// File: rtl/bitchk_checker.sv
module bitchk_checker (
  input logic clk,
  input logic rstN,
  input logic tickEn,
  input logic startStb,
  input logic pollCmd,
  input logic passPulse,
  input logic failPulse,
  input logic rxMode,
  input logic dataOut
);

  assert_fail_needs_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failPulse) |-> $past(tickEn));

  assert_pass_enters_rx_R3: assert property (@(posedge clk) disable iff (!rstN)
    passPulse |-> rxMode);

  assert_fail_leaves_rx_R4: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |-> !rxMode);

  assert_rx_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode && !pollCmd) |=> rxMode);

  assert_poll_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    pollCmd |=> (!rxMode && !passPulse && !failPulse));

  assert_poll_out_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rxMode |-> dataOut);

  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(passPulse && failPulse));

  assert_pass_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    passPulse |=> !passPulse);

  assert_fail_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |=> !failPulse);

endmodule

bind edge_bitcheck bitchk_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .startStb  (startStb),
  .pollCmd   (pollCmd),
  .passPulse (passPulse),
  .failPulse (failPulse),
  .rxMode    (rxMode),
  .dataOut   (dataOut)
);

// File: tb/sim_edge_bitcheck.sv
module sim_edge_bitcheck;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       dataIn = 1'b1;
  logic [7:0] limLo = 8'd4;
  logic [7:0] limHi = 8'd8;
  logic [3:0] bitCount = 4'd0;
  logic       startStb = 1'b0;
  logic       pollCmd = 1'b0;
  logic       passPulse, failPulse, rxMode, dataOut;

  int checks = 0;
  int errors = 0;
  int passSeen = 0;
  int failSeen = 0;
  bit slowMode = 1'b0;
  int divCnt = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  edge_bitcheck u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .dataIn(dataIn),
    .limLo(limLo), .limHi(limHi), .bitCount(bitCount),
    .startStb(startStb), .pollCmd(pollCmd),
    .passPulse(passPulse), .failPulse(failPulse),
    .rxMode(rxMode), .dataOut(dataOut)
  );

  typedef struct packed {
    logic [3:0] need;
    logic [7:0] lo;
    logic [7:0] hi;
    logic [2:0] n;
    logic [7:0] i0;
    logic [7:0] i1;
    logic [7:0] i2;
    logic [7:0] i3;
    logic [7:0] i4;
    logic       expPass;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{4'd3, 8'd4, 8'd8,  3'd3, 8'd5, 8'd6,  8'd7, 8'd0, 8'd0, 1'b1},
    '{4'd3, 8'd4, 8'd8,  3'd2, 8'd5, 8'd3,  8'd0, 8'd0, 8'd0, 1'b0},
    '{4'd2, 8'd4, 8'd8,  3'd2, 8'd4, 8'd8,  8'd0, 8'd0, 8'd0, 1'b1},
    '{4'd4, 8'd4, 8'd8,  3'd3, 8'd5, 8'd5,  8'd9, 8'd0, 8'd0, 1'b0},
    '{4'd1, 8'd2, 8'd3,  3'd1, 8'd3, 8'd0,  8'd0, 8'd0, 8'd0, 1'b1},
    '{4'd5, 8'd3, 8'd10, 3'd5, 8'd3, 8'd10, 8'd4, 8'd9, 8'd6, 1'b1},
    '{4'd2, 8'd5, 8'd6,  3'd2, 8'd6, 8'd4,  8'd0, 8'd0, 8'd0, 1'b0}
  };

  // tick generator: every cycle, or one in three in slow mode
  always @(negedge clk) begin
    divCnt <= (divCnt == 2) ? 0 : divCnt + 1;
    tickEn <= slowMode ? (divCnt == 0) : 1'b1;
  end

  // pulse monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (passPulse) passSeen <= passSeen + 1;
      if (failPulse) failSeen <= failSeen + 1;
      if (passPulse && failPulse) begin
        errors <= errors + 1;
        $display("FAIL R10 pass and fail together: act=1 exp=0");
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulsePoll();
    @(negedge clk); pollCmd = 1'b1;
    @(negedge clk); pollCmd = 1'b0;
  endtask

  // strobe start, then give the first edge
  task automatic doStart(input logic [3:0] need);
    @(negedge clk); bitCount = need; startStb = 1'b1;
    @(negedge clk); startStb = 1'b0; dataIn = ~dataIn;
  endtask

  task automatic gap(input int len);
    repeat (len) @(negedge clk);
    dataIn = ~dataIn;
  endtask

  function automatic int pick(input vec_t v, input int k);
    case (k)
      0: return int'(v.i0);
      1: return int'(v.i1);
      2: return int'(v.i2);
      3: return int'(v.i3);
      default: return int'(v.i4);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: act=1 exp=0");
    report();
  end

  initial begin
    int p0, f0;
    repeat (3) @(negedge clk);
    chk("R1", "rxMode after reset", rxMode, 0);
    chk("R1", "passPulse after reset", passPulse, 0);
    chk("R1", "failPulse after reset", failPulse, 0);
    chk("R1", "dataOut after reset", dataOut, 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: R3 pass runs, R4 short, R5 boundary and timeout
    for (int v = 0; v < NVEC; v++) begin
      pulsePoll();
      limLo = VECS[v].lo;
      limHi = VECS[v].hi;
      p0 = passSeen; f0 = failSeen;
      doStart(VECS[v].need);
      for (int k = 0; k < int'(VECS[v].n); k++) gap(pick(VECS[v], k));
      repeat (3) @(negedge clk);
      chk(VECS[v].expPass ? "R3" : (v == 3 ? "R5" : "R4"), $sformatf("vec %0d passes", v),
          passSeen - p0, int'(VECS[v].expPass));
      chk(v == 3 ? "R5" : "R4", $sformatf("vec %0d fails", v),
          failSeen - f0, int'(!VECS[v].expPass));
      chk("R3", $sformatf("vec %0d rxMode", v), rxMode, int'(VECS[v].expPass));
      chk("R8", $sformatf("vec %0d dataOut", v), dataOut,
          VECS[v].expPass ? int'(dataIn) : 1);
    end

    // R8: receive mode follows the data (last vector left polling, redo a pass)
    pulsePoll();
    limLo = 8'd4; limHi = 8'd8;
    doStart(4'd1); gap(5);
    repeat (3) @(negedge clk);
    chk("R8", "rx before data toggle", rxMode, 1);
    dataIn = ~dataIn;
    repeat (2) @(negedge clk);
    chk("R8", "dataOut follows dataIn", dataOut, int'(dataIn));

    // R7: start ignored in receive mode, poll clears it
    p0 = passSeen; f0 = failSeen;
    doStart(4'd1); gap(2);
    repeat (12) @(negedge clk);
    chk("R7", "rx kept after start", rxMode, 1);
    chk("R7", "no pulses in rx", (passSeen - p0) + (failSeen - f0), 0);
    pulsePoll();
    @(negedge clk);
    chk("R7", "rx cleared by poll", rxMode, 0);
    chk("R8", "dataOut high in polling", dataOut, 1);

    // R7: poll aborts a running check silently
    p0 = passSeen; f0 = failSeen;
    doStart(4'd2); gap(5);
    pulsePoll();
    gap(5); gap(5);
    repeat (3) @(negedge clk);
    chk("R7", "abort gives no pulses", (passSeen - p0) + (failSeen - f0), 0);
    chk("R7", "abort leaves polling", rxMode, 0);

    // R6: zero count start ignored
    p0 = passSeen; f0 = failSeen;
    doStart(4'd0); gap(5); gap(5);
    repeat (3) @(negedge clk);
    chk("R6", "zero count no pulses", (passSeen - p0) + (failSeen - f0), 0);
    chk("R6", "zero count stays polling", rxMode, 0);

    // R6: count captured at the strobe
    p0 = passSeen;
    doStart(4'd2);
    bitCount = 4'd9;
    gap(5); gap(5);
    repeat (3) @(negedge clk);
    chk("R6", "captured count used", passSeen - p0, 1);
    pulsePoll();

    // R9: restart discards progress
    p0 = passSeen; f0 = failSeen;
    doStart(4'd3); gap(5); gap(5);
    doStart(4'd3); gap(5); gap(5);
    repeat (3) @(negedge clk);
    chk("R9", "no pass after two post-restart", passSeen - p0, 0);
    gap(5);
    repeat (3) @(negedge clk);
    chk("R9", "pass after third post-restart", passSeen - p0, 1);
    chk("R9", "no fail on restart", failSeen - f0, 0);
    pulsePoll();

    // R2: tick-based timing with slow ticks (12 cycles = 4 ticks)
    slowMode = 1'b1;
    repeat (4) @(negedge clk);
    limLo = 8'd3; limHi = 8'd4;
    p0 = passSeen;
    doStart(4'd1); gap(12);
    repeat (8) @(negedge clk);
    chk("R2", "4 ticks in 3..4 passes", passSeen - p0, 1);
    pulsePoll();
    limLo = 8'd10; limHi = 8'd14;
    p0 = passSeen; f0 = failSeen;
    doStart(4'd1); gap(12);
    repeat (8) @(negedge clk);
    chk("R2", "4 ticks in 10..14 fails", failSeen - f0, 1);
    chk("R2", "4 ticks in 10..14 no pass", passSeen - p0, 0);
    slowMode = 1'b0;

    report();
  end

endmodule